// File: doc/BRIEF.md
# Preemptive Prioritized Interrupt Arbiter

The block sits beside a processor core and decides which of up to 82 interrupt request lines is taken next. Each line carries a 4-bit priority, where a smaller value means more urgent. A split setting divides that value into an upper group field and a lower sub field. Only the group field decides whether a request may interrupt a running handler. The full value, and then the line number, decide which of several eligible requests wins.

Requests can be held off in two ways: a global mask blocks everything, and a non-zero threshold blocks requests at or below a given urgency. The block keeps its own nesting record of active handler priorities. One entry is pushed per preemption and one is popped per completion. When a handler completes while another eligible request is waiting, the block chains into it with a short delay and does not do a full exit and re-entry. Fixed-length cycle counters stand in for the entry and chaining delays of the core.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `take_o` and `act_valid_o` are 0.
- R2: Among eligible pending lines, the one with the numerically smallest 4-bit priority wins; on equal priority the lowest line index wins. Line indices run from 0 to 81, and bit i of `pend_i` and bits [4i+3:4i] of `prio_i` belong to line i.
- R3: While `gmask_i` is 1, no request is taken, neither fresh nor chained.
- R4: When `thr_i` is non-zero, a request whose priority is greater than or equal to `thr_i` is not eligible. When `thr_i` is 0, no threshold masking applies.
- R5: A fresh entry raises `take_o` for exactly one cycle, with `chained_o` = 0, on the 12th rising clock edge after the edge that accepts the request. From the edge at which the request first becomes visible, `take_o` is seen high after 13 edges.
- R6: The group field is the priority shifted right by `grp_split_i` (0..4 sub bits). While a handler is active, a request is accepted only if its group field is strictly smaller than the group field of the active priority. An equal group field never preempts. With no handler active, any eligible request is accepted.
- R7: A `done_i` pulse while a handler is active chains when an eligible request has a group field strictly smaller than that of the next-outer handler, or when no outer handler exists. In that case `take_o` rises with `chained_o` = 1 on the 6th edge after the completion edge, and `act_prio_o` is replaced by the new priority without any change in nesting depth.
- R8: A `done_i` pulse that does not chain pops the nesting record on that edge. `act_prio_o` then shows the outer priority, or `act_valid_o` drops to 0.
- R9: At each `take_o` pulse, `act_valid_o` is 1 and `act_prio_o` equals the priority of the line given on `line_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 82 | Pending request bit per line |
| prio_i | input | 328 | 4-bit priority per line, packed |
| grp_split_i | input | 3 | Number of low sub-priority bits (0..4) |
| gmask_i | input | 1 | Global mask: blocks all requests |
| thr_i | input | 4 | Priority threshold, 0 = off |
| done_i | input | 1 | Active handler completion strobe |
| take_o | output | 1 | One-cycle pulse: handler starts |
| line_o | output | 7 | Line taken, valid with `take_o` |
| chained_o | output | 1 | 1 if the take was a chained entry |
| act_valid_o | output | 1 | A handler is active |
| act_prio_o | output | 4 | Priority of innermost active handler |

## Verification
The bench goes after ordering corners: full ties between lines resolved by index, requests that share a group but have a better sub field, and the top line index. A design that compared full priorities for preemption would nest a same-group request, and one that scanned in the wrong direction would take the higher index. Threshold edges (priority equal to the threshold, threshold zero) and the global mask are exercised, where an off-by-one compare would let a blocked request through. A completion with a waiting request is checked both when chaining is allowed and when the outer handler forbids it. A design that always chained, always popped, or pushed instead of replacing would show wrong latency, a wrong `chained_o` or a wrong `act_prio_o`.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    NEST_HOLD,
    NEST_PUSH,
    NEST_POP,
    NEST_SWAP
  } nest_op_e;
endpackage

// File: rtl/irq_arb_select.sv
module irq_arb_select #(
  parameter int NUM_LINES = 82,
  parameter int PRIO_W    = 4,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  input  logic                        gmask_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic                        hit_o,
  output logic [LINE_W-1:0]           line_o,
  output logic [PRIO_W-1:0]           prio_o
);
  always_comb begin
    logic [PRIO_W-1:0] p;
    logic ok;
    hit_o  = 1'b0;
    line_o = '0;
    prio_o = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      p  = prio_i[i*PRIO_W +: PRIO_W];
      ok = pend_i[i] && !gmask_i && ((thr_i == '0) || (p < thr_i));
      // strict compare plus ascending scan keeps the lowest index on ties
      if (ok && (!hit_o || (p < prio_o))) begin
        hit_o  = 1'b1;
        prio_o = p;
        line_o = LINE_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_arb_timer.sv
module irq_arb_timer #(
  parameter int ENTRY_CYC = 12,
  parameter int CHAIN_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic chain_i,
  output logic busy_o,
  output logic fire_o
);
  localparam int MAX_CYC = (ENTRY_CYC > CHAIN_CYC) ? ENTRY_CYC : CHAIN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= chain_i ? CNT_W'(CHAIN_CYC) : CNT_W'(ENTRY_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign fire_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/irq_arb_nest.sv
module irq_arb_nest
  import irq_arb_pkg::*;
#(
  parameter int PRIO_W     = 4,
  parameter int NEST_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  nest_op_e          op_i,
  input  logic [PRIO_W-1:0] wdata_i,
  output logic              top_valid_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic              outer_valid_o,
  output logic [PRIO_W-1:0] outer_prio_o
);
  localparam int IDX_W   = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;
  localparam int DEPTH_W = $clog2(NEST_DEPTH + 1);

  logic [PRIO_W-1:0]  stk_q [NEST_DEPTH];
  logic [DEPTH_W-1:0] depth_q;
  logic [IDX_W-1:0]   top_idx, outer_idx;

  assign top_idx   = IDX_W'(depth_q - DEPTH_W'(1));
  assign outer_idx = IDX_W'(depth_q - DEPTH_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < NEST_DEPTH; i++) stk_q[i] <= '0;
    end else begin
      case (op_i)
        NEST_PUSH: if (depth_q < DEPTH_W'(NEST_DEPTH)) begin
          stk_q[IDX_W'(depth_q)] <= wdata_i;
          depth_q <= depth_q + DEPTH_W'(1);
        end
        NEST_POP:  if (depth_q != '0) depth_q <= depth_q - DEPTH_W'(1);
        NEST_SWAP: if (depth_q != '0) stk_q[top_idx] <= wdata_i;
        default: ;
      endcase
    end
  end

  assign top_valid_o   = (depth_q != '0);
  assign top_prio_o    = top_valid_o ? stk_q[top_idx] : '0;
  assign outer_valid_o = (depth_q > DEPTH_W'(1));
  assign outer_prio_o  = outer_valid_o ? stk_q[outer_idx] : '0;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_LINES  = 82,
  parameter int PRIO_W     = 4,
  parameter int NEST_DEPTH = 16,
  parameter int ENTRY_CYC  = 12,
  parameter int CHAIN_CYC  = 6,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int SPLIT_W   = $clog2(PRIO_W + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  input  logic [SPLIT_W-1:0]          grp_split_i,
  input  logic                        gmask_i,
  input  logic [PRIO_W-1:0]           thr_i,
  input  logic                        done_i,
  output logic                        take_o,
  output logic [LINE_W-1:0]           line_o,
  output logic                        chained_o,
  output logic                        act_valid_o,
  output logic [PRIO_W-1:0]           act_prio_o
);
  function automatic logic [PRIO_W-1:0] grp_of(logic [PRIO_W-1:0] p, logic [SPLIT_W-1:0] s);
    return p >> s;
  endfunction

  logic              sel_hit, busy, fire;
  logic [LINE_W-1:0] sel_line;
  logic [PRIO_W-1:0] sel_prio, top_prio, outer_prio;
  logic              top_valid, outer_valid;
  logic              preempt_ok, chain_ok, complete, accept_fresh, accept_chain;
  nest_op_e          nest_op;

  logic [LINE_W-1:0] line_q;
  logic [PRIO_W-1:0] prio_q;
  logic              chain_q, take_q;

  irq_arb_select #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .LINE_W(LINE_W)) u_select (
    .pend_i (pend_i),
    .prio_i (prio_i),
    .gmask_i(gmask_i),
    .thr_i  (thr_i),
    .hit_o  (sel_hit),
    .line_o (sel_line),
    .prio_o (sel_prio)
  );

  irq_arb_timer #(.ENTRY_CYC(ENTRY_CYC), .CHAIN_CYC(CHAIN_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept_fresh || accept_chain),
    .chain_i(accept_chain),
    .busy_o (busy),
    .fire_o (fire)
  );

  irq_arb_nest #(.PRIO_W(PRIO_W), .NEST_DEPTH(NEST_DEPTH)) u_nest (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (nest_op),
    .wdata_i      (prio_q),
    .top_valid_o  (top_valid),
    .top_prio_o   (top_prio),
    .outer_valid_o(outer_valid),
    .outer_prio_o (outer_prio)
  );

  // nesting decided by group field only
  assign preempt_ok = sel_hit && (!top_valid ||
                      (grp_of(sel_prio, grp_split_i) < grp_of(top_prio, grp_split_i)));
  // a chained request must be allowed to run over the context below the finishing one
  assign chain_ok   = sel_hit && (!outer_valid ||
                      (grp_of(sel_prio, grp_split_i) < grp_of(outer_prio, grp_split_i)));

  assign complete     = !busy && done_i && top_valid;
  assign accept_chain = complete && chain_ok;
  assign accept_fresh = !busy && !complete && preempt_ok;

  always_comb begin
    if (fire)                     nest_op = chain_q ? NEST_SWAP : NEST_PUSH;
    else if (complete && !chain_ok) nest_op = NEST_POP;
    else                          nest_op = NEST_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      prio_q  <= '0;
      chain_q <= 1'b0;
      take_q  <= 1'b0;
    end else begin
      take_q <= fire;
      if (accept_fresh || accept_chain) begin
        line_q  <= sel_line;
        prio_q  <= sel_prio;
        chain_q <= accept_chain;
      end
    end
  end

  assign take_o      = take_q;
  assign line_o      = line_q;
  assign chained_o   = chain_q;
  assign act_valid_o = top_valid;
  assign act_prio_o  = top_prio;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NUM_LINES = 82,
  parameter int PRIO_W    = 4,
  parameter int ENTRY_CYC = 12,
  parameter int CHAIN_CYC = 6,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int SPLIT_W   = $clog2(PRIO_W + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gmask_i,
  input logic [SPLIT_W-1:0] grp_split_i,
  input logic              take_o,
  input logic [LINE_W-1:0] line_o,
  input logic              chained_o,
  input logic              act_valid_o,
  input logic [PRIO_W-1:0] act_prio_o
);
  localparam int LIM   = ENTRY_CYC + CHAIN_CYC + 1;
  localparam int RUN_W = $clog2(LIM + 1);

  logic [RUN_W-1:0] mask_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mask_run <= '0;
    else if (!gmask_i)                    mask_run <= '0;
    else if (mask_run != RUN_W'(LIM))     mask_run <= mask_run + RUN_W'(1);
  end

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |=> (!take_o && !act_valid_o));

  p_line_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (int'(line_o) < NUM_LINES));

  p_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_run == RUN_W'(LIM)) |-> !take_o);

  p_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  p_deeper_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !chained_o && $past(act_valid_o)) |->
      ((act_prio_o >> grp_split_i) < ($past(act_prio_o) >> $past(grp_split_i))));

  p_chain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && chained_o) |-> $past(act_valid_o));

  p_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> act_valid_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ENTRY_CYC(ENTRY_CYC), .CHAIN_CYC(CHAIN_CYC),
  .LINE_W(LINE_W), .SPLIT_W(SPLIT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gmask_i    (gmask_i),
  .grp_split_i(grp_split_i),
  .take_o     (take_o),
  .line_o     (line_o),
  .chained_o  (chained_o),
  .act_valid_o(act_valid_o),
  .act_prio_o (act_prio_o)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  localparam int NL    = 82;
  localparam int PW    = 4;
  localparam int ENTRY = 12;
  localparam int CHAIN = 6;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NL-1:0]  pend_i = '0;
  logic [NL*PW-1:0] prio_i = '0;
  logic [2:0]     grp_split_i = '0;
  logic           gmask_i = 1'b0;
  logic [PW-1:0]  thr_i = '0;
  logic           done_i = 1'b0;
  logic           take_o, chained_o, act_valid_o;
  logic [6:0]     line_o;
  logic [PW-1:0]  act_prio_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  irq_arbiter u_irq_arbiter (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_line(int i, bit p, int pr);
    pend_i[i] = p;
    prio_i[i*PW +: PW] = PW'(pr);
  endtask

  // counts posedges until take_o is seen at a negedge; 0 if none within max
  task automatic wait_take(int max, output int n);
    bit got = 0;
    n = 0;
    while (n < max && !got) begin
      @(posedge clk_i); n++;
      @(negedge clk_i); done_i = 1'b0;
      if (take_o) got = 1;
    end
    if (!got) n = 0;
  endtask

  task automatic count_takes(int cyc, output int c);
    c = 0;
    for (int k = 0; k < cyc; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (take_o) c++;
    end
  endtask

  task automatic pulse_done();
    done_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    done_i = 1'b0;
  endtask

  function automatic int exp_winner(logic [PW-1:0] thr, bit gm);
    int best = -1;
    int bp = 99;
    if (gm) return -1;
    for (int i = 0; i < NL; i++) begin
      int p = int'(prio_i[i*PW +: PW]);
      if (pend_i[i] && (thr == 0 || p < int'(thr)) && p < bp) begin
        bp = p; best = i;
      end
    end
    return best;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, c, w;
    void'($urandom(32'h1a2b3c));
    repeat (3) @(negedge clk_i);
    check(!take_o && !act_valid_o, "R1 reset", int'(take_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!take_o && !act_valid_o, "R1 after reset", int'(act_valid_o), 0);

    // R3 global mask
    gmask_i = 1'b1; set_line(3, 1, 2);
    count_takes(30, c);
    check(c == 0, "R3 masked take", c, 0);
    gmask_i = 1'b0;
    wait_take(40, n);
    check(n == ENTRY + 1, "R5 entry latency", n, ENTRY + 1);
    check(line_o == 3 && !chained_o, "R2 line", int'(line_o), 3);
    check(act_prio_o == 2, "R9 act prio", int'(act_prio_o), 2);
    set_line(3, 0, 0);
    @(negedge clk_i);
    check(!take_o, "R5 single pulse", int'(take_o), 0);
    pulse_done();
    check(!act_valid_o, "R8 pop to idle", int'(act_valid_o), 0);

    // R4 threshold
    thr_i = 4'd5; set_line(10, 1, 5);
    count_takes(30, c);
    check(c == 0, "R4 prio equal thr blocked", c, 0);
    set_line(10, 1, 4);
    wait_take(40, n);
    check(n == ENTRY + 1 && line_o == 10, "R4 prio below thr taken", int'(line_o), 10);
    set_line(10, 0, 0); pulse_done();
    thr_i = 4'd0; set_line(81, 1, 15);
    wait_take(40, n);
    check(n == ENTRY + 1 && line_o == 81, "R4 thr zero / R2 top line", int'(line_o), 81);
    set_line(81, 0, 0); pulse_done();

    // R2 tie
    set_line(20, 1, 6); set_line(7, 1, 6); set_line(50, 1, 6);
    wait_take(40, n);
    check(line_o == 7, "R2 tie lowest index", int'(line_o), 7);
    pend_i = '0; pulse_done();

    // R6 / R7 / R8 nesting with 2 sub bits
    grp_split_i = 3'd2;
    set_line(1, 1, 8);
    wait_take(40, n);
    set_line(1, 0, 0);
    set_line(2, 1, 9);
    count_takes(30, c);
    check(c == 0, "R6 equal group no preempt", c, 0);
    set_line(4, 1, 7);
    wait_take(40, n);
    check(n == ENTRY + 1 && line_o == 4 && !chained_o, "R6 preempt", int'(line_o), 4);
    check(act_prio_o == 7, "R9 nested prio", int'(act_prio_o), 7);
    set_line(4, 0, 0);
    set_line(5, 1, 4);
    count_takes(30, c);
    check(c == 0, "R6 same group better sub no preempt", c, 0);
    done_i = 1'b1;
    wait_take(40, n);
    check(n == CHAIN + 1 && line_o == 5 && chained_o, "R7 chain", n, CHAIN + 1);
    check(act_prio_o == 4, "R7 replaced prio", int'(act_prio_o), 4);
    set_line(5, 0, 0);
    pulse_done();
    check(act_valid_o && act_prio_o == 8, "R8 pop to outer", int'(act_prio_o), 8);
    count_takes(20, c);
    check(c == 0, "R8 no chain when outer blocks", c, 0);
    done_i = 1'b1;
    wait_take(40, n);
    check(n == CHAIN + 1 && line_o == 2 && chained_o, "R7 chain from last", int'(line_o), 2);
    check(act_prio_o == 9, "R7 prio", int'(act_prio_o), 9);
    set_line(2, 0, 0);
    pulse_done();
    check(!act_valid_o, "R8 idle", int'(act_valid_o), 0);

    // random single-level arbitration
    for (int it = 0; it < 60; it++) begin
      @(negedge clk_i);
      grp_split_i = 3'($urandom % 5);
      thr_i = PW'($urandom % 16);
      for (int i = 0; i < NL; i++) set_line(i, ($urandom % 8) == 0, $urandom % 16);
      w = exp_winner(thr_i, 1'b0);
      if (w < 0) begin
        count_takes(20, c);
        check(c == 0, "R4 random nothing eligible", c, 0);
        pend_i = '0;
      end else begin
        wait_take(40, n);
        check(n == ENTRY + 1, "R5 random latency", n, ENTRY + 1);
        check(int'(line_o) == w, "R2 random winner", int'(line_o), w);
        check(act_prio_o == prio_i[w*PW +: PW], "R9 random prio",
              int'(act_prio_o), int'(prio_i[w*PW +: PW]));
        pend_i = '0;
        pulse_done();
        check(!act_valid_o, "R8 random pop", int'(act_valid_o), 0);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule